// File: doc/BRIEF.md
# Converter Serial Master Output Port

This block sits behind a data converter and sends each 16-bit result out on a self-clocked serial link. It watches a conversion-start pulse and a conversion-done pulse that comes with the result word. It keeps a BUSY flag for the time a conversion is running. It also generates the bit clock, the serial data line and a frame-sync output itself. The serial clock is the system clock divided down: each half-period lasts `SCLK_HALF` system clocks.

Two read modes are offered. In read-after mode, a frame starts as soon as a new result is captured, and that new result is sent. In read-during mode, a frame starts with the conversion-start pulse and carries the result that was captured last, while the new conversion runs. Pin-level controls select the sync polarity, the serial clock polarity and the output coding (two's complement or offset binary). A frame is launched only while chip-select and read-enable are both low.

Top module: `ser_master_port`

## Requirements
- R1: `busy` is 1 in the cycle after a cycle with `conv_start`=1. It is 0 in the cycle after a cycle with `conv_done`=1 and `conv_start`=0. Otherwise it holds its value. Reset clears it.
- R2: A frame shifts out the 16-bit frame word most significant bit first. Each bit stays on `sdout` for 2*`SCLK_HALF` system clocks.
- R3: `sync` takes the level NOT `sync_inv` from the cycle after launch until the frame ends. At all other times it rests at the level `sync_inv`.
- R4: With `read_prev`=1, a frame launches on `conv_start` and carries the word captured at the most recent `conv_done`. With `read_prev`=0, a frame launches on `conv_done` and carries the word arriving on `conv_data` in that cycle.
- R5: Within a frame, `sclk` starts at the level `sclk_inv` and toggles every `SCLK_HALF` system clocks. `sdout` changes only at transitions back to the level `sclk_inv`, so it is stable when `sclk` moves away from `sclk_inv`.
- R6: A launch happens only when `cs_n`=0 and `rd_n`=0 in the launching cycle. Otherwise the event starts no frame, but a `conv_done` word is still captured.
- R7: With `fmt_obin`=1, the captured word is `conv_data` with bit 15 inverted (offset binary). With `fmt_obin`=0, it is `conv_data` unchanged. The coding is fixed at capture time.
- R8: Outside a frame, `sdout` is 0 and `sclk` is at the level `sclk_inv`.
- R9: Each frame has exactly 16 transitions of `sclk` away from the level `sclk_inv` and lasts 32*`SCLK_HALF` system clocks. After that, `sync` returns to its resting level.
- R10: A launch event that arrives while a frame is in progress is ignored. The running frame continues with its word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | One-cycle pulse: a conversion begins |
| conv_done | input | 1 | One-cycle pulse: `conv_data` holds a finished result |
| conv_data | input | 16 | Two's-complement result word |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| fmt_obin | input | 1 | 1 selects offset-binary coding |
| sync_inv | input | 1 | 1 makes `sync` active low |
| sclk_inv | input | 1 | 1 inverts `sclk` (idle high) |
| read_prev | input | 1 | 1 selects read-during-convert mode |
| sclk | output | 1 | Serial bit clock |
| sdout | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame sync |
| busy | output | 1 | Conversion in progress |

## Verification
`busy` follows a start or done pulse one cycle after the edge that samples it. `sync` and the first data bit appear one cycle after the launching edge. After that, `sclk` toggles every `SCLK_HALF` cycles, and `sync` falls 32*`SCLK_HALF` cycles after it rose. The bench model advances its own integer counters at every rising edge from the same inputs. It compares all four outputs at the falling edge of each cycle, so every latency above is checked in the exact cycle it is due. A port-level monitor rebuilds each received word from `sdout` at the transitions of `sclk` away from its resting level. Directed checks then compare the word, the edge count and the frame count against constants worked out by hand for the coding, polarity, read-mode, disable and ignored-launch cases.

// File: rtl/smp_pkg.sv
`timescale 1ns/1ps
package smp_pkg;

  typedef enum logic {
    RD_AFTER  = 1'b0,
    RD_DURING = 1'b1
  } rd_mode_e;

  // Coding of the top bit: offset binary flips the sign bit.
  function automatic logic coded_msb(input logic twos_msb, input logic obin);
    return twos_msb ^ obin;
  endfunction

endpackage

// File: rtl/smp_result_hold.sv
`timescale 1ns/1ps
module smp_result_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic         conv_done,
  input  logic [W-1:0] conv_data,
  input  logic         fmt_obin,
  output logic         busy,
  output logic [W-1:0] held_word,
  output logic [W-1:0] fresh_word
);
  import smp_pkg::*;

  always_comb begin
    fresh_word      = conv_data;
    fresh_word[W-1] = coded_msb(conv_data[W-1], fmt_obin);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      held_word <= '0;
    end else begin
      if (conv_start)     busy <= 1'b1;
      else if (conv_done) busy <= 1'b0;
      if (conv_done) held_word <= fresh_word;
    end
  end

endmodule

// File: rtl/smp_bit_timer.sv
`timescale 1ns/1ps
module smp_bit_timer #(
  parameter int SCLK_HALF = 2,
  parameter int BITS      = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic frame_active,
  output logic sclk_base,
  output logic bit_shift,
  output logic frame_end
);
  localparam int CW     = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int PHASES = 2 * BITS;
  localparam int IW     = $clog2(PHASES);

  logic [CW-1:0] cnt;
  logic [IW-1:0] half_idx;
  logic          phase_end;

  assign phase_end = frame_active && (cnt == CW'(SCLK_HALF - 1));
  assign bit_shift = phase_end && half_idx[0];
  assign frame_end = phase_end && (half_idx == IW'(PHASES - 1));
  assign sclk_base = frame_active && half_idx[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_active <= 1'b0;
      cnt          <= '0;
      half_idx     <= '0;
    end else if (launch && !frame_active) begin
      frame_active <= 1'b1;
      cnt          <= '0;
      half_idx     <= '0;
    end else if (frame_active) begin
      if (phase_end) begin
        cnt <= '0;
        if (frame_end) frame_active <= 1'b0;
        else           half_idx     <= half_idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/smp_shift_out.sv
`timescale 1ns/1ps
module smp_shift_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] shreg;

  assign msb = shreg[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= load_word;
    else if (shift) shreg <= {shreg[W-2:0], 1'b0};
  end

endmodule

// File: rtl/ser_master_port.sv
`timescale 1ns/1ps
module ser_master_port #(
  parameter int W         = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic         conv_done,
  input  logic [W-1:0] conv_data,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         fmt_obin,
  input  logic         sync_inv,
  input  logic         sclk_inv,
  input  logic         read_prev,
  output logic         sclk,
  output logic         sdout,
  output logic         sync,
  output logic         busy
);
  import smp_pkg::*;

  rd_mode_e     mode;
  logic         port_en;
  logic         launch;
  logic         frame_active;
  logic         sclk_base;
  logic         bit_shift;
  logic         frame_end;
  logic         shift_msb;
  logic [W-1:0] held_word;
  logic [W-1:0] fresh_word;
  logic [W-1:0] frame_word;

  assign mode       = rd_mode_e'(read_prev);
  assign port_en    = !cs_n && !rd_n;
  assign launch     = port_en && !frame_active &&
                      ((mode == RD_DURING) ? conv_start : conv_done);
  assign frame_word = (mode == RD_DURING) ? held_word : fresh_word;

  smp_result_hold #(.W(W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .fmt_obin   (fmt_obin),
    .busy       (busy),
    .held_word  (held_word),
    .fresh_word (fresh_word)
  );

  smp_bit_timer #(.SCLK_HALF(SCLK_HALF), .BITS(W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .frame_active (frame_active),
    .sclk_base    (sclk_base),
    .bit_shift    (bit_shift),
    .frame_end    (frame_end)
  );

  smp_shift_out #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .load_word (frame_word),
    .shift     (bit_shift),
    .msb       (shift_msb)
  );

  assign sclk  = sclk_base ^ sclk_inv;
  assign sdout = frame_active && shift_msb;
  assign sync  = frame_active ^ sync_inv;

endmodule

// File: rtl/smp_checker.sv
`timescale 1ns/1ps
module smp_checker (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic conv_done,
  input logic cs_n,
  input logic rd_n,
  input logic sync_inv,
  input logic sclk_inv,
  input logic sclk,
  input logic sdout,
  input logic sync,
  input logic busy,
  input logic launch,
  input logic frame_active,
  input logic sclk_base,
  input logic frame_end
);

  p_busy_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy);

  p_busy_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !conv_start) |=> !busy);

  p_sync_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && $stable(sync_inv)) |=> (sync != sync_inv));

  p_sdout_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_base) |-> $stable(sdout));

  p_no_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && (cs_n || rd_n)) |=> !frame_active);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> (!sdout && (sclk == sclk_inv)));

  p_frame_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && $stable(sync_inv)) |=> (sync == sync_inv));

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !frame_end) |=> frame_active);

  p_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(busy) || conv_start || conv_done || $past(conv_start) || $past(conv_done));

endmodule

bind ser_master_port smp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_start   (conv_start),
  .conv_done    (conv_done),
  .cs_n         (cs_n),
  .rd_n         (rd_n),
  .sync_inv     (sync_inv),
  .sclk_inv     (sclk_inv),
  .sclk         (sclk),
  .sdout        (sdout),
  .sync         (sync),
  .busy         (busy),
  .launch       (launch),
  .frame_active (frame_active),
  .sclk_base    (sclk_base),
  .frame_end    (frame_end)
);

// File: tb/ser_master_port_test.sv
`timescale 1ns/1ps
module ser_master_port_test;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic        cs_n = 1'b0, rd_n = 1'b0;
  logic        fmt_obin = 1'b0, sync_inv = 1'b0, sclk_inv = 1'b0, read_prev = 1'b0;
  logic        sclk, sdout, sync, busy;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  ser_master_port #(.W(16), .SCLK_HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
    .conv_data(conv_data), .cs_n(cs_n), .rd_n(rd_n), .fmt_obin(fmt_obin),
    .sync_inv(sync_inv), .sclk_inv(sclk_inv), .read_prev(read_prev),
    .sclk(sclk), .sdout(sdout), .sync(sync), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Behavioural reference: integer position within the frame.
  bit          m_active = 1'b0, m_busy = 1'b0;
  int          m_k = 0;
  logic [15:0] m_word = '0, m_res = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_active = 1'b0; m_busy = 1'b0; m_k = 0; m_word = '0; m_res = '0;
    end else begin
      bit          en, go;
      logic [15:0] coded;
      coded = conv_data;
      if (fmt_obin) coded[15] = ~coded[15];
      en = !cs_n && !rd_n;
      go = en && !m_active && (read_prev ? conv_start : conv_done);
      if (m_active) begin
        m_k++;
        if (m_k == 32 * H) m_active = 1'b0;
      end
      if (go) begin
        m_active = 1'b1;
        m_k = 0;
        m_word = read_prev ? m_res : coded;
      end
      if (conv_start)     m_busy = 1'b1;
      else if (conv_done) m_busy = 1'b0;
      if (conv_done) m_res = coded;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit e_sclk, e_sdout, e_sync;
      e_sclk  = (m_active ? (((m_k / H) % 2) == 1) : 1'b0) ^ sclk_inv;
      e_sdout = m_active ? m_word[15 - (m_k / (2 * H))] : 1'b0;
      e_sync  = m_active ^ sync_inv;
      chk(busy == m_busy,   "R1 busy",         busy,  m_busy);
      chk(sdout == e_sdout, "R2/R8 sdout",     sdout, e_sdout);
      chk(sync == e_sync,   "R3 sync",         sync,  e_sync);
      chk(sclk == e_sclk,   "R5/R8 sclk",      sclk,  e_sclk);
    end
  end

  // Port-level receiver.
  bit          mon_on = 1'b0, mon_base = 1'b0;
  int          mon_edges = 0, last_edges = 0, frames = 0;
  logic [15:0] mon_word = '0, last_word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit s_on, base;
      s_on = (sync != sync_inv);
      base = (sclk != sclk_inv);
      if (s_on && base && !mon_base) begin
        mon_word = {mon_word[14:0], sdout};
        mon_edges++;
      end
      if (!s_on && mon_on) begin
        last_word = mon_word; last_edges = mon_edges; frames++; mon_edges = 0;
      end
      mon_on = s_on; mon_base = base;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_start();
    @(posedge clk); #2 conv_start = 1'b1;
    @(posedge clk); #2 conv_start = 1'b0;
  endtask

  task automatic pulse_done(input logic [15:0] d);
    @(posedge clk); #2 conv_done = 1'b1; conv_data = d;
    @(posedge clk); #2 conv_done = 1'b0;
  endtask

  initial begin
    int f0;
    step(3);
    rst_n = 1'b1;
    step(1);
    #2;
    // Reset state.
    chk(busy == 1'b0,  "R1 reset busy",  busy,  0);
    chk(sdout == 1'b0, "R8 reset sdout", sdout, 0);
    chk(sclk == 1'b0,  "R8 reset sclk",  sclk,  0);
    chk(sync == 1'b0,  "R3 reset sync",  sync,  0);

    // Read-after, two's complement.
    pulse_start();
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    step(5);
    pulse_done(16'h1234);
    chk(busy == 1'b0, "R1 busy after done", busy, 0);
    step(80);
    chk(last_word == 16'h1234, "R2 msb-first word", last_word, 16'h1234);
    chk(last_edges == 16, "R9 edge count", last_edges, 16);
    chk(frames == 1, "R4 read-after frame", frames, 1);

    // Offset binary.
    fmt_obin = 1'b1;
    pulse_done(16'h1234);
    step(80);
    chk(last_word == 16'h9234, "R7 offset binary", last_word, 16'h9234);

    // Inverted sync and clock.
    fmt_obin = 1'b0; sync_inv = 1'b1; sclk_inv = 1'b1;
    step(2);
    chk(sync == 1'b1 && sclk == 1'b1 && sdout == 1'b0, "R8 inverted idle",
        {sync, sclk, sdout}, 3'b110);
    pulse_done(16'h8001);
    step(80);
    chk(last_word == 16'h8001, "R3 R5 inverted polarity word", last_word, 16'h8001);
    chk(last_edges == 16, "R9 inverted edge count", last_edges, 16);

    // Launch during a frame is ignored.
    sync_inv = 1'b0; sclk_inv = 1'b0;
    step(2);
    f0 = frames;
    pulse_done(16'h0F0F);
    step(20);
    pulse_done(16'hFFFF);
    step(80);
    chk(last_word == 16'h0F0F, "R10 word kept", last_word, 16'h0F0F);
    chk(frames == f0 + 1, "R10 single frame", frames, f0 + 1);

    // Read during convert.
    read_prev = 1'b1;
    step(2);
    pulse_start();
    step(10);
    pulse_done(16'hBEEF);
    step(80);
    chk(last_word == 16'hFFFF, "R4 previous result", last_word, 16'hFFFF);
    pulse_start();
    step(80);
    chk(last_word == 16'hBEEF, "R4 next previous result", last_word, 16'hBEEF);
    pulse_done(16'h0001);

    // Enable gating.
    read_prev = 1'b0; cs_n = 1'b1;
    step(2);
    f0 = frames;
    pulse_done(16'h5555);
    step(80);
    chk(frames == f0, "R6 cs_n high", frames, f0);
    cs_n = 1'b0; rd_n = 1'b1;
    pulse_done(16'h6666);
    step(80);
    chk(frames == f0, "R6 rd_n high", frames, f0);
    rd_n = 1'b0; read_prev = 1'b1;
    step(2);
    pulse_start();
    step(80);
    chk(last_word == 16'h6666, "R6 word captured while disabled", last_word, 16'h6666);
    pulse_done(16'h0000);
    step(5);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done_flag) begin
      done_flag = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule